// File: doc/BRIEF.md
# Predicated Vector Compare-to-Predicate Unit

This unit evaluates a conditional branch that has been widened to vectors. For each element index from zero up to the vector length it compares one element of the first operand with one element of the second, writes the outcome into a destination predicate mask, and at the end reports whether the branch should be taken. The branch is taken only when every compare that was not masked out succeeded. The register file sits outside the block: the unit drives one read index per operand and takes the element value back in the same cycle.

Either operand may be a vector or a scalar. A scalar operand always supplies its element zero, so it is compared against every element of the other operand. When both operands are scalar the unit performs a single plain compare and leaves the predicate alone. The source predicate, which masks the compares, belongs to the first operand. The destination predicate, which the unit updates, belongs to the second operand; the caller selects both registers and passes their values in. A zeroing control chooses between two update rules. With zeroing off, passing compares set their bit and nothing is ever cleared. With zeroing on, every element inside the vector length is written, and masked or failing elements read zero. The "greater than" and "less or equal" forms are obtained with an operand-swap control rather than extra codes.

The unit handles one element per clock and pulses `done` once the taken flag and the predicate are final.

Top module: `vcmp_pred_unit`

## Requirements
- R1: After reset `busy`, `done`, `taken` and `dst_pred` are all zero.
- R2: `cmp_op` codes: 0 equal, 1 not equal, 2 signed less than, 3 signed greater or equal, 4 unsigned less than, 5 unsigned greater or equal; codes 6 and 7 make every compare fail.
- R3: With `swap_src` set each compare uses the second operand element as its left side and the first as its right side, which yields greater-than and less-or-equal from codes 2 to 5.
- R4: A scalar operand (its vector flag 0) keeps its read index at 0 for the whole run, so its element 0 is compared against every element of the vector operand.
- R5: Element i is active only when bit i of `src_pred` is 1; an inactive element never affects `taken`, and with zeroing off its destination bit keeps its value.
- R6: With `zeroing` 0 the predicate starts from `dst_pred_init`; an active passing element sets its bit, a failing one leaves it, and no bit is ever cleared.
- R7: With `zeroing` 1 an active passing element writes 1, an active failing element writes 0 and an inactive element writes 0; bits at or above the vector length keep their `dst_pred_init` value.
- R8: `taken` is 1 exactly when no active element failed, so it is 1 when the vector length is 0 or all elements are masked out.
- R9: When both vector flags are 0 one compare of element 0 is done, `src_pred` is ignored, `dst_pred` equals `dst_pred_init` and `taken` is the compare result.
- R10: A start accepted while idle processes one element per cycle: `done` is high for exactly one cycle, N clock edges after the start edge for N elements (on the start edge itself when N is 0), and a `start` seen while busy is ignored.
- R11: A `vl` above MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a compare run (taken only when idle) |
| cmp_op | input | 3 | Compare code (see R2) |
| swap_src | input | 1 | Exchange compare sides |
| zeroing | input | 1 | Select zeroing predicate update |
| src1_vec | input | 1 | First operand is a vector |
| src2_vec | input | 1 | Second operand is a vector |
| vl | input | VL_W | Vector length for this run |
| src_pred | input | MAX_VL | Element mask from the first operand |
| dst_pred_init | input | MAX_VL | Current value of the destination predicate |
| rd_idx1 | output | IDX_W | Element read index, first operand |
| rd_idx2 | output | IDX_W | Element read index, second operand |
| src1_data | input | DATA_W | Element value at `rd_idx1` |
| src2_data | input | DATA_W | Element value at `rd_idx2` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: results final |
| taken | output | 1 | Branch-taken flag |
| dst_pred | output | MAX_VL | Updated destination predicate |

## Verification
The bench goes after the two predicate update rules on a preset destination: a design that cleared on failure without zeroing would lose preset ones, and one that skipped masked elements under zeroing would leave stale ones. It drives values with the top bit set so a signed/unsigned mix-up flips the result, and uses reserved codes that must always fail. It runs zero length, fully masked and over-length vectors, where a wrong design would report not-taken, hang or read past the end, and sends a start during a run, which a careless sequencer would restart on. Scalar operands are watched on the read index, since a design broadcasting the wrong element would step it.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    parameter int unsigned DEF_DATA_W = 16;
    parameter int unsigned DEF_MAX_VL = 8;

    typedef enum logic [2:0] {
        CMP_EQ   = 3'd0,
        CMP_NE   = 3'd1,
        CMP_LT   = 3'd2,
        CMP_GE   = 3'd3,
        CMP_LTU  = 3'd4,
        CMP_GEU  = 3'd5,
        CMP_RSV6 = 3'd6,
        CMP_RSV7 = 3'd7
    } cmp_op_e;

    // run configuration captured when a start is accepted
    typedef struct packed {
        cmp_op_e op;
        logic    swap;
        logic    zeroing;
        logic    v1;
        logic    v2;
    } cmp_cfg_t;

    // relation flags produced by the comparator datapath
    typedef struct packed {
        logic eq;
        logic lt_s;
        logic lt_u;
    } cmp_flags_t;

    function automatic logic cmp_decide(input cmp_op_e op, input cmp_flags_t f);
        logic r;
        case (op)
            CMP_EQ:  r = f.eq;
            CMP_NE:  r = !f.eq;
            CMP_LT:  r = f.lt_s;
            CMP_GE:  r = !f.lt_s;
            CMP_LTU: r = f.lt_u;
            CMP_GEU: r = !f.lt_u;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vcmp_alu.sv
module vcmp_alu
    import vcmp_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  cmp_op_e           op,
    input  logic              swap,
    output logic              pass
);
    logic [DATA_W-1:0] lhs;
    logic [DATA_W-1:0] rhs;
    cmp_flags_t        flags;

    always_comb begin
        lhs      = swap ? b_in : a_in;
        rhs      = swap ? a_in : b_in;
        flags.eq   = (lhs == rhs);
        flags.lt_s = ($signed(lhs) < $signed(rhs));
        flags.lt_u = (lhs < rhs);
        pass     = cmp_decide(op, flags);
    end
endmodule

// File: rtl/vcmp_seq.sv
module vcmp_seq #(
    parameter int unsigned MAX_VL = vcmp_pkg::DEF_MAX_VL,
    parameter int unsigned VL_W   = $clog2(MAX_VL + 1),
    parameter int unsigned IDX_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             scalar_mode,
    input  logic [VL_W-1:0]  vl,
    output logic             load,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] idx
);
    localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

    logic [VL_W-1:0] len_d;
    logic [VL_W-1:0] len_q;
    logic            at_last;

    always_comb begin
        load = start && !busy;
        if (scalar_mode)
            len_d = VL_W'(1);
        else if (vl > VL_CAP)
            len_d = VL_CAP;
        else
            len_d = vl;
        at_last = ((VL_W'(idx) + VL_W'(1)) == len_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            idx   <= '0;
            len_q <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                idx   <= '0;
                len_q <= len_d;
                if (len_d == '0)
                    done <= 1'b1;
                else
                    busy <= 1'b1;
            end else if (busy) begin
                if (at_last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (VL_W'(idx) < len_q));                                  // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                 // R10
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (len_q == $past(len_q)));                    // R10
    AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (rst)
        busy |-> (len_q <= VL_CAP));                                     // R11
endmodule

// File: rtl/vcmp_mask.sv
module vcmp_mask #(
    parameter int unsigned MAX_VL = vcmp_pkg::DEF_MAX_VL,
    parameter int unsigned IDX_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MAX_VL-1:0] init,
    input  logic              step,
    input  logic [IDX_W-1:0]  idx,
    input  logic              active,
    input  logic              pass,
    input  logic              zeroing,
    input  logic              scalar_mode,
    output logic [MAX_VL-1:0] pred,
    output logic              all_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pred   <= '0;
            all_ok <= 1'b0;
        end else if (load) begin
            pred   <= init;
            all_ok <= 1'b1;
        end else if (step) begin
            if (!scalar_mode) begin
                if (active && pass)
                    pred[idx] <= 1'b1;
                else if (zeroing)
                    pred[idx] <= 1'b0;
            end
            if (active && !pass)
                all_ok <= 1'b0;
        end
    end

    AST_NO_CLEAR_WITHOUT_ZEROING: assert property (@(posedge clk) disable iff (rst)
        (step && !zeroing) |=> ((pred & $past(pred)) == $past(pred)));    // R6
    AST_FAIL_DROPS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (step && active && !pass) |=> !all_ok);                          // R8
    AST_SCALAR_PRED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step && scalar_mode) |=> $stable(pred));                        // R9
    AST_ZERO_MASKED: assert property (@(posedge clk) disable iff (rst)
        (step && zeroing && !active && !scalar_mode) |=> (pred[$past(idx)] == 1'b0)); // R7
    AST_MASKED_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (step && !active) |=> (all_ok == $past(all_ok)));                // R5
endmodule

// File: rtl/vcmp_pred_unit.sv
module vcmp_pred_unit
    import vcmp_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned MAX_VL = DEF_MAX_VL,
    parameter int unsigned VL_W   = $clog2(MAX_VL + 1),
    parameter int unsigned IDX_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        cmp_op,
    input  logic              swap_src,
    input  logic              zeroing,
    input  logic              src1_vec,
    input  logic              src2_vec,
    input  logic [VL_W-1:0]   vl,
    input  logic [MAX_VL-1:0] src_pred,
    input  logic [MAX_VL-1:0] dst_pred_init,
    output logic [IDX_W-1:0]  rd_idx1,
    output logic [IDX_W-1:0]  rd_idx2,
    input  logic [DATA_W-1:0] src1_data,
    input  logic [DATA_W-1:0] src2_data,
    output logic              busy,
    output logic              done,
    output logic              taken,
    output logic [MAX_VL-1:0] dst_pred
);
    cmp_cfg_t          cfg_q;
    logic [MAX_VL-1:0] mask_q;
    logic              load;
    logic [IDX_W-1:0]  idx;
    logic              scalar_now;
    logic              scalar_q;
    logic              elem_active;
    logic              elem_pass;

    assign scalar_now = !src1_vec && !src2_vec;
    assign scalar_q   = !cfg_q.v1 && !cfg_q.v2;

    vcmp_seq #(
        .MAX_VL (MAX_VL),
        .VL_W   (VL_W),
        .IDX_W  (IDX_W)
    ) i_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .scalar_mode (scalar_now),
        .vl          (vl),
        .load        (load),
        .busy        (busy),
        .done        (done),
        .idx         (idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '0;
        end else if (load) begin
            cfg_q.op      <= cmp_op_e'(cmp_op);
            cfg_q.swap    <= swap_src;
            cfg_q.zeroing <= zeroing;
            cfg_q.v1      <= src1_vec;
            cfg_q.v2      <= src2_vec;
            mask_q        <= src_pred;
        end
    end

    assign rd_idx1     = cfg_q.v1 ? idx : '0;
    assign rd_idx2     = cfg_q.v2 ? idx : '0;
    assign elem_active = scalar_q ? 1'b1 : mask_q[idx];

    vcmp_alu #(
        .DATA_W (DATA_W)
    ) i_alu (
        .a_in (src1_data),
        .b_in (src2_data),
        .op   (cfg_q.op),
        .swap (cfg_q.swap),
        .pass (elem_pass)
    );

    vcmp_mask #(
        .MAX_VL (MAX_VL),
        .IDX_W  (IDX_W)
    ) i_mask (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .init        (dst_pred_init),
        .step        (busy),
        .idx         (idx),
        .active      (elem_active),
        .pass        (elem_pass),
        .zeroing     (cfg_q.zeroing),
        .scalar_mode (scalar_q),
        .pred        (dst_pred),
        .all_ok      (taken)
    );

    AST_SCALAR_INDEX_FIXED: assert property (@(posedge clk) disable iff (rst)
        (busy && !cfg_q.v1) |=> (rd_idx1 == '0));                        // R4
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                 // R10
    AST_RESERVED_FAILS: assert property (@(posedge clk) disable iff (rst)
        (busy && (cfg_q.op == CMP_RSV6 || cfg_q.op == CMP_RSV7)) |-> !elem_pass); // R2
endmodule

// File: tb/test_vcmp_pred_unit.sv
module test_vcmp_pred_unit;
    localparam int DW = 16;
    localparam int NV = 8;
    localparam int VW = 4;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    cmp_op = 3'd0;
    logic          swap_src = 1'b0;
    logic          zeroing = 1'b0;
    logic          src1_vec = 1'b1;
    logic          src2_vec = 1'b1;
    logic [VW-1:0] vl = '0;
    logic [NV-1:0] src_pred = '0;
    logic [NV-1:0] dst_pred_init = '0;
    logic [IW-1:0] rd_idx1, rd_idx2;
    logic [DW-1:0] src1_data, src2_data;
    logic          busy, done, taken;
    logic [NV-1:0] dst_pred;

    logic [DW-1:0] mem_a [NV];
    logic [DW-1:0] mem_b [NV];

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign src1_data = mem_a[rd_idx1];
    assign src2_data = mem_b[rd_idx2];

    vcmp_pred_unit i_vcmp_pred_unit (
        .clk(clk), .rst(rst), .start(start), .cmp_op(cmp_op), .swap_src(swap_src),
        .zeroing(zeroing), .src1_vec(src1_vec), .src2_vec(src2_vec), .vl(vl),
        .src_pred(src_pred), .dst_pred_init(dst_pred_init),
        .rd_idx1(rd_idx1), .rd_idx2(rd_idx2),
        .src1_data(src1_data), .src2_data(src2_data),
        .busy(busy), .done(done), .taken(taken), .dst_pred(dst_pred)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic ref_cmp(input logic [2:0] op, input logic [DW-1:0] x, input logic [DW-1:0] y);
        case (op)
            3'd0: return x == y;
            3'd1: return x != y;
            3'd2: return $signed(x) <  $signed(y);
            3'd3: return $signed(x) >= $signed(y);
            3'd4: return x <  y;
            3'd5: return x >= y;
            default: return 1'b0;
        endcase
    endfunction

    // expected outcome built from the requirements
    task automatic model(output logic [NV-1:0] ep, output logic et, output int ecyc);
        int n;
        logic [DW-1:0] x, y;
        logic ok;
        ep = dst_pred_init;
        et = 1'b1;
        if (!src1_vec && !src2_vec) n = 1;
        else n = (int'(vl) > NV) ? NV : int'(vl);
        ecyc = n;
        for (int i = 0; i < n; i++) begin
            x = src1_vec ? mem_a[i] : mem_a[0];
            y = src2_vec ? mem_b[i] : mem_b[0];
            ok = swap_src ? ref_cmp(cmp_op, y, x) : ref_cmp(cmp_op, x, y);
            if (!src1_vec && !src2_vec) begin
                et = ok;
            end else if (src_pred[i]) begin
                if (ok) ep[i] = 1'b1;
                else begin
                    et = 1'b0;
                    if (zeroing) ep[i] = 1'b0;
                end
            end else if (zeroing) begin
                ep[i] = 1'b0;
            end
        end
    endtask

    task automatic run_case(input string req);
        logic [NV-1:0] ep;
        logic et;
        int ecyc, cyc;
        bit idx1_moved, idx2_moved;
        model(ep, et, ecyc);
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        cyc = 0;
        idx1_moved = 0;
        idx2_moved = 0;
        while (!done && cyc < 100) begin
            if (rd_idx1 != 0) idx1_moved = 1;
            if (rd_idx2 != 0) idx2_moved = 1;
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        check({req, " dst_pred"}, 32'(dst_pred), 32'(ep));
        check({req, " taken"}, 32'(taken), 32'(et));
        check({req, " R10 done cycle"}, 32'(cyc), 32'(ecyc));
        if (!src1_vec) check({req, " R4 idx1 fixed"}, 32'(idx1_moved), 32'd0);
        if (!src2_vec) check({req, " R4 idx2 fixed"}, 32'(idx2_moved), 32'd0);
        @(posedge clk);
        @(negedge clk);
        check({req, " R10 done pulse"}, 32'(done), 32'd0);
    endtask

    task automatic set_cfg(input logic [2:0] op, input logic sw, input logic z,
                           input logic a_v, input logic b_v, input logic [VW-1:0] n,
                           input logic [NV-1:0] sp, input logic [NV-1:0] ip);
        cmp_op = op; swap_src = sw; zeroing = z; src1_vec = a_v; src2_vec = b_v;
        vl = n; src_pred = sp; dst_pred_init = ip;
    endtask

    task automatic load_base();
        mem_a[0] = 16'd5;    mem_b[0] = 16'd5;
        mem_a[1] = 16'hFFFD; mem_b[1] = 16'd4;
        mem_a[2] = 16'd7;    mem_b[2] = 16'd7;
        mem_a[3] = 16'h8000; mem_b[3] = 16'd1;
        mem_a[4] = 16'd2;    mem_b[4] = 16'd3;
        mem_a[5] = 16'd9;    mem_b[5] = 16'd9;
        mem_a[6] = 16'd0;    mem_b[6] = 16'd1;
        mem_a[7] = 16'hFFFF; mem_b[7] = 16'd1;
    endtask

    task automatic t_reset();
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 taken", 32'(taken), 0);
        check("R1 dst_pred", 32'(dst_pred), 0);
    endtask

    task automatic t_ops();
        load_base();
        for (int op = 0; op < 8; op++) begin
            set_cfg(3'(op), 1'b0, 1'b0, 1'b1, 1'b1, 4'd8, 8'hFF, 8'h00);
            run_case("R2 op");
            if (op == 0) check("R2 eq literal", 32'(dst_pred), 32'h25);
            if (op >= 6) check("R2 reserved literal", 32'(dst_pred), 32'h00);
        end
    endtask

    task automatic t_swap();
        load_base();
        for (int op = 2; op < 6; op++) begin
            set_cfg(3'(op), 1'b1, 1'b0, 1'b1, 1'b1, 4'd8, 8'hFF, 8'h00);
            run_case("R3 swap");
        end
    endtask

    task automatic t_broadcast();
        load_base();
        set_cfg(3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8, 8'hFF, 8'h00);
        run_case("R4 vector-scalar");
        set_cfg(3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4'd8, 8'hFF, 8'hFF);
        run_case("R4 scalar-vector");
    endtask

    task automatic t_mask_nonzero();
        load_base();
        set_cfg(3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8, 8'b0101_1010, 8'b1100_0011);
        run_case("R5 R6 masked keep");
        set_cfg(3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8, 8'b1010_1010, 8'hFF);
        run_case("R6 no clear");
        check("R6 literal", 32'(dst_pred), 32'hFF);
    endtask

    task automatic t_zeroing();
        load_base();
        set_cfg(3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6, 8'b0010_0101, 8'hFF);
        run_case("R7 zeroing");
        check("R7 literal", 32'(dst_pred), 32'b1110_0101);
    endtask

    task automatic t_taken_edges();
        load_base();
        set_cfg(3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 8'hFF, 8'h3C);
        run_case("R8 vl zero");
        check("R8 vl zero taken", 32'(taken), 1);
        set_cfg(3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8, 8'h25, 8'h00);
        run_case("R8 only passing active");
        check("R8 taken literal", 32'(taken), 1);
        set_cfg(3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8, 8'h00, 8'h18);
        run_case("R8 all masked");
        check("R8 all masked taken", 32'(taken), 1);
    endtask

    task automatic t_scalar();
        load_base();
        set_cfg(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8, 8'h00, 8'hA5);
        run_case("R9 scalar eq");
        check("R9 taken literal", 32'(taken), 1);
        set_cfg(3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8, 8'hFF, 8'h5A);
        run_case("R9 scalar ne");
        check("R9 pred literal", 32'(dst_pred), 32'h5A);
    endtask

    task automatic t_clamp();
        load_base();
        set_cfg(3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 4'd15, 8'hFF, 8'h00);
        run_case("R11 clamp");
    endtask

    task automatic t_start_busy();
        logic [NV-1:0] ep;
        logic et;
        int ecyc, cyc;
        load_base();
        set_cfg(3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8, 8'hFF, 8'h00);
        model(ep, et, ecyc);
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        set_cfg(3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd1, 8'h00, 8'hFF);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        cyc = 2;
        while (!done && cyc < 100) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        check("R10 busy start pred", 32'(dst_pred), 32'(ep));
        check("R10 busy start taken", 32'(taken), 32'(et));
        check("R10 busy start cycles", 32'(cyc), 32'(ecyc));
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        load_base();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_ops();
        t_swap();
        t_broadcast();
        t_mask_nonzero();
        t_zeroing();
        t_taken_edges();
        t_scalar();
        t_clamp();
        t_start_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule